// File: doc/BRIEF.md
# Boundary-Scan I/O Cell Chain

This block is the boundary-scan data register for a group of bidirectional pads. Each pad has three scan cells: one for the value coming in from the pad, one for the value driven out, and one for the output-enable. Every cell has a shift stage, clocked on the rising test-clock edge, and an update latch, loaded on the falling edge. All the shift stages form one serial chain from the test data input to the test data output. A small decoder watches the instruction register contents and turns on external-test mode when the all-zero code becomes current.

In functional mode the pads follow the core's output and enable, and the core sees the real pad input. In external-test mode the update latches take over. The output and enable latches drive the pad, and the input latch is sent into the core in place of the pad value. The update latches load on every Update-DR strobe, whatever instruction is current. Test values can therefore be staged under another instruction before external-test is selected, and they can also be overwritten that way. The TAP state machine and the instruction shift path are outside the block; it only receives their state strobes.

Top module: `bscan_io_chain`

## Requirements
- R1: External-test mode is active only after an Update-IR strobe while the instruction code is 3'b000. An Update-IR strobe with any other code (for example 3'b001 or 3'b111) makes it inactive.
- R2: The mode changes only on the falling TCK edge that samples `updateIr` high. Changing `irCode` without that strobe has no effect on the pads.
- R3: With external-test inactive, `padOut`=`coreOut`, `padOe`=`coreOe` and `coreIn`=`padIn`.
- R4: With external-test active, for pad p `coreIn[p]` is taken from update latch 3p, `padOut[p]` from latch 3p+1 and `padOe[p]` from latch 3p+2.
- R5: On a rising TCK edge with `captureDr` high, chain bit 3p takes `padIn[p]`, bit 3p+1 takes `coreOut[p]` and bit 3p+2 takes `coreOe[p]`. `captureDr` has priority over `shiftDr`.
- R6: On a rising TCK edge with `shiftDr` high, `tdi` enters chain bit 0 and every bit moves one place up. `tdo` is updated on the falling edge from the top bit, 3*NUM_PADS-1, so the captured bits leave highest index first.
- R7: Update latches hold their values while data shifts, so the pad outputs in external-test mode do not change during Shift-DR.
- R8: The update latches load from the shift stages on the falling TCK edge that samples `updateDr`, under any instruction. Data loaded under a non-test code becomes visible when external-test is selected later.
- R9: An active-low asynchronous `trstN` clears every update latch, which leaves every enable latch at 0 (high-impedance). It also clears the shift stages and `tdo`, and leaves external-test inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| captureDr | input | 1 | TAP is in Capture-DR |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| updateIr | input | 1 | TAP is in Update-IR |
| irCode | input | IR_WIDTH | Current instruction register contents |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| coreOut | input | NUM_PADS | Core output value per pad |
| coreOe | input | NUM_PADS | Core output enable per pad, 1 = drive |
| padIn | input | NUM_PADS | Value seen on each pad |
| padOut | output | NUM_PADS | Value driven to each pad |
| padOe | output | NUM_PADS | Pad driver enable, 1 = drive |
| coreIn | output | NUM_PADS | Input value delivered to the core |

## Verification
The bench builds the block with the default four pads, which gives a 12-bit chain. At that size each pattern reaches the first and the last pad, and the edge cells at both ends of the chain. The captured streams put differing values in the two top bits, so a `tdo` change on the wrong edge shows up. Test data is staged under non-test codes and released only by selecting the test code, and it is overwritten under another code. A reset arrives while the block is in test mode. Every bit of the three latch fields passes through the pad-facing outputs.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Strobes and mode passed from the control to the cell chain
  typedef struct packed {
    logic capture;
    logic shift;
    logic updDr;
    logic extest;
  } scanCtl_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
#(
  parameter int              IR_WIDTH    = 3,
  parameter logic [IR_WIDTH-1:0] EXTEST_CODE = '0
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                updateIr,
  input  logic [IR_WIDTH-1:0] irCode,
  output scanCtl_t            ctl
);

  logic extestReg;

  // The instruction becomes current on the falling edge in Update-IR
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)        extestReg <= 1'b0;
    else if (updateIr) extestReg <= (irCode == EXTEST_CODE);
  end

  always_comb begin
    ctl.capture = captureDr;
    ctl.shift   = shiftDr;
    ctl.updDr   = updateDr;
    ctl.extest  = extestReg;
  end

  // R2
  mode_hold_chk: assert property (@(negedge tck) disable iff (!trstN)
    !$past(updateIr) |-> $stable(extestReg));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                tck,
  input  logic                trstN,
  input  scanCtl_t            ctl,
  input  logic                tdi,
  input  logic [NUM_PADS-1:0] coreOut,
  input  logic [NUM_PADS-1:0] coreOe,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] coreIn,
  output logic                tdo
);

  localparam int CHAIN_LEN = 3 * NUM_PADS;
  localparam int LAST      = CHAIN_LEN - 1;

  logic [LAST:0] shiftStage;
  logic [LAST:0] updLatch;
  logic [LAST:0] captureVal;
  logic [LAST:0] shiftNext;

  // Per pad: cell 3p = input, 3p+1 = output, 3p+2 = enable
  for (genvar p = 0; p < NUM_PADS; p++) begin : gPad
    localparam int B = 3 * p;
    assign captureVal[B]   = padIn[p];
    assign captureVal[B+1] = coreOut[p];
    assign captureVal[B+2] = coreOe[p];
    assign coreIn[p] = ctl.extest ? updLatch[B]   : padIn[p];
    assign padOut[p] = ctl.extest ? updLatch[B+1] : coreOut[p];
    assign padOe[p]  = ctl.extest ? updLatch[B+2] : coreOe[p];
  end

  assign shiftNext = {shiftStage[LAST-1:0], tdi};

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)           shiftStage <= '0;
    else if (ctl.capture) shiftStage <= captureVal;
    else if (ctl.shift)   shiftStage <= shiftNext;
  end

  // Update latches load on every Update-DR, whatever the instruction
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)         updLatch <= '0;
    else if (ctl.updDr) updLatch <= shiftStage;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= shiftStage[LAST];
  end

  // R7
  latch_hold_chk: assert property (@(negedge tck) disable iff (!trstN)
    !$past(ctl.updDr) |-> $stable(updLatch));

  // R5
  capture_ends_chk: assert property (@(posedge tck) disable iff (!trstN)
    ctl.capture |=> (shiftStage[0] == $past(padIn[0])) &&
                    (shiftStage[LAST] == $past(coreOe[NUM_PADS-1])));

  // R6
  shift_entry_chk: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.shift && !ctl.capture) |=> shiftStage[0] == $past(tdi));

  // R6
  tdo_track_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdo == shiftStage[LAST]);

endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int IR_WIDTH = 3
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                updateIr,
  input  logic [IR_WIDTH-1:0] irCode,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] coreOut,
  input  logic [NUM_PADS-1:0] coreOe,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] coreIn
);

  scanCtl_t ctl;

  bscan_ctrl #(
    .IR_WIDTH   (IR_WIDTH),
    .EXTEST_CODE('0)
  ) uCtrl (
    .tck      (tck),
    .trstN    (trstN),
    .captureDr(captureDr),
    .shiftDr  (shiftDr),
    .updateDr (updateDr),
    .updateIr (updateIr),
    .irCode   (irCode),
    .ctl      (ctl)
  );

  bscan_chain #(
    .NUM_PADS(NUM_PADS)
  ) uChain (
    .tck    (tck),
    .trstN  (trstN),
    .ctl    (ctl),
    .tdi    (tdi),
    .coreOut(coreOut),
    .coreOe (coreOe),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .coreIn (coreIn),
    .tdo    (tdo)
  );

endmodule

// File: tb/tb_bscan_io_chain.sv
`timescale 1ns/1ps
module tb_bscan_io_chain;

  localparam int NUM_PADS = 4;
  localparam int IR_WIDTH = 3;
  localparam int CHAIN    = 3 * NUM_PADS;
  localparam int LAST     = CHAIN - 1;

  logic tck = 1'b0;
  logic trstN, captureDr, shiftDr, updateDr, updateIr, tdi, tdo;
  logic [IR_WIDTH-1:0] irCode;
  logic [NUM_PADS-1:0] coreOut, coreOe, padIn, padOut, padOe, coreIn;

  int checks = 0;
  int errors = 0;
  bit expQ[$];
  string tagQ[$];

  always #2.5 tck = ~tck;

  bscan_io_chain #(.NUM_PADS(NUM_PADS), .IR_WIDTH(IR_WIDTH)) dut (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .updateIr(updateIr), .irCode(irCode), .tdi(tdi),
    .tdo(tdo), .coreOut(coreOut), .coreOe(coreOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .coreIn(coreIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares tdo just after each falling edge against the scoreboard
  always @(negedge tck) begin
    #1;
    if (expQ.size() > 0) begin
      automatic bit e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk(t, {31'b0, tdo}, {31'b0, e});
    end
  end

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  task automatic push(input bit e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  function automatic logic [NUM_PADS-1:0] field(input logic [LAST:0] v, input int sel);
    logic [NUM_PADS-1:0] r;
    for (int p = 0; p < NUM_PADS; p++) r[p] = v[3*p+sel];
    return r;
  endfunction

  task automatic loadIr(input logic [IR_WIDTH-1:0] code);
    irCode = code;
    updateIr = 1'b1;
    step();
    updateIr = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateDr = 1'b1;
    step();
    updateDr = 1'b0;
  endtask

  // Driver: capture, shift a new vector in, push the expected tdo stream
  task automatic dataScan(input logic [LAST:0] vin, input bit doUpdate);
    logic [LAST:0] cap;
    for (int p = 0; p < NUM_PADS; p++) begin
      cap[3*p]   = padIn[p];
      cap[3*p+1] = coreOut[p];
      cap[3*p+2] = coreOe[p];
    end
    captureDr = 1'b1;
    step();
    captureDr = 1'b0;
    push(cap[LAST], "R5 captured top bit on tdo");
    shiftDr = 1'b1;
    for (int j = 0; j <= LAST; j++) begin
      tdi = vin[LAST-j];
      step();
      // R6: tdo must still hold the previous bit until the falling edge
      if (j == 0) chk("R6 tdo held until falling edge", {31'b0, tdo}, {31'b0, cap[LAST]});
      if (j < LAST) push(cap[LAST-1-j], "R6 captured stream on tdo");
      else          push(vin[LAST], "R6 first shifted bit reaches tdo");
    end
    shiftDr = 1'b0;
    if (doUpdate) pulseUpdate();
  endtask

  task automatic chkPads(input string tag, input logic [NUM_PADS-1:0] eo,
                         input logic [NUM_PADS-1:0] ee, input logic [NUM_PADS-1:0] ei);
    chk({tag, " padOut"}, {28'b0, padOut}, {28'b0, eo});
    chk({tag, " padOe"},  {28'b0, padOe},  {28'b0, ee});
    chk({tag, " coreIn"}, {28'b0, coreIn}, {28'b0, ei});
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LAST:0] vA, vB, vC;
    vA = 12'hA5C; vB = 12'h3B6; vC = 12'hC39;
    trstN = 1'b0; captureDr = 0; shiftDr = 0; updateDr = 0; updateIr = 0;
    tdi = 0; irCode = 3'b111;
    coreOut = 4'b1010; coreOe = 4'b0110; padIn = 4'b0011;
    step(); step(); step();
    // R9 reset state: functional pads, tdo low
    chkPads("R9 reset functional", 4'b1010, 4'b0110, 4'b0011);
    chk("R9 reset tdo", {31'b0, tdo}, 32'd0);
    trstN = 1'b1;
    step();

    // R1 R9 R4: test mode right after reset shows cleared latches
    loadIr(3'b000);
    chkPads("R9 cleared latches in test mode", 4'b0000, 4'b0000, 4'b0000);

    // R2: code change without Update-IR has no effect
    irCode = 3'b110;
    step(); step();
    chkPads("R2 no strobe keeps test mode", 4'b0000, 4'b0000, 4'b0000);

    // R1 R3: other codes give functional mode
    loadIr(3'b111);
    chkPads("R1 code 111 functional", 4'b1010, 4'b0110, 4'b0011);
    coreOut = 4'b0101; coreOe = 4'b1001; padIn = 4'b1100;
    loadIr(3'b001);
    #1;
    chkPads("R3 code 001 functional", 4'b0101, 4'b1001, 4'b1100);

    // R5 R6 R8: stage vA under a non-test code
    coreOut = 4'b0110; coreOe = 4'b1011; padIn = 4'b0101;
    dataScan(vA, 1'b1);
    #1;
    chkPads("R8 staged data hidden outside test", 4'b0110, 4'b1011, 4'b0101);
    loadIr(3'b000);
    chkPads("R8 R4 staged data released", field(vA,1), field(vA,2), field(vA,0));

    // R7 R5: scan in test mode without update, outputs hold
    coreOut = 4'b1001; coreOe = 4'b0100; padIn = 4'b1110;
    dataScan(vB, 1'b0);
    chkPads("R7 latches hold during shift", field(vA,1), field(vA,2), field(vA,0));
    pulseUpdate();
    chkPads("R4 new latch values", field(vB,1), field(vB,2), field(vB,0));

    // R8: overwrite under bypass-like code, then reselect test
    loadIr(3'b111);
    chkPads("R3 functional again", 4'b1001, 4'b0100, 4'b1110);
    dataScan(vC, 1'b1);
    loadIr(3'b000);
    chkPads("R8 overwritten data", field(vC,1), field(vC,2), field(vC,0));

    // R9: asynchronous reset while in test mode
    trstN = 1'b0;
    #1;
    chkPads("R9 async reset functional", 4'b1001, 4'b0100, 4'b1110);
    chk("R9 async reset tdo", {31'b0, tdo}, 32'd0);
    step(); step();
    trstN = 1'b1;
    step();
    loadIr(3'b000);
    chkPads("R9 latches cleared by reset", 4'b0000, 4'b0000, 4'b0000);

    step(); step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule